// File: doc/BRIEF.md
# Clock Controller Register Bank

This block is the configuration store of a system clock controller. Software reaches it through a 32-bit peripheral bus with APB-style signals and uses it to hold the setup words for nine PLL channels. It also holds the CPU/AXI and peripheral-bus divider settings, a DRAM configuration word, a memory-bus reset word, two PLL settling-time words, and the per-PLL bias and tuning words. No clock is generated or gated here. The bank only keeps the words and returns them, so the rest of the chip and the firmware see a consistent view.

Two write side effects stand in for hardware that is not modelled. First, a PLL that is switched on reports lock at once. Second, the DRAM "apply settings" request bit always reads back as already cleared. Access is by whole 32-bit words, and the word index is the byte address shifted right by two. Offsets with no register, and every offset from 0x308 upward, read zero and take no writes.

Top module: `ccr_bank`

## Requirements
- R1: While `rst` is high at a rising edge, every register takes its own default on that edge. Examples: word 0x000 = 0x00001000, 0x0F4 = 0x00000000, 0x0FC = 0x80000000, 0x200 = 0x000000FF, 0x204 = 0x000000FF, 0x230 = 0x81104000, 0x260 = 0x14880000.
- R2: The PLL control words sit at byte offsets 0x000, 0x008, 0x010, 0x018, 0x020, 0x028, 0x038, 0x044 and 0x048. When a write to one of them has bit 31 (enable) set, the stored word has bit 28 (lock) set as well, whatever bit 28 of the written data was.
- R3: A write to a PLL control word with bit 31 clear stores the data unchanged, including the written value of bit 28.
- R4: In every write to the DRAM configuration word at 0x0F4, bit 16 is stored as zero and all other bits are stored as written.
- R5: All other mapped words store written data unchanged. These are 0x050, 0x054, 0x058, 0x0FC, 0x200, 0x204, 0x220, 0x224, 0x228, 0x22C, 0x230, 0x234, 0x23C, 0x244, 0x248, 0x250 and 0x260.
- R6: `prdata` is zero whenever `paddr` is 0x308 or above.
- R7: A write at an address of 0x308 or above changes no stored register, including registers whose index matches the low address bits.
- R8: Unmapped word offsets below 0x308 (for example 0x004) read zero, and writes to them change no register.
- R9: A write is taken on the rising edge where `psel`, `penable` and `pwrite` are all high. `prdata` shows the word addressed by `paddr` without delay, so a read in the next cycle returns the adjusted new value.
- R10: No register changes on an edge where `psel`, `penable` and `pwrite` are not all high. A setup phase with `penable` low writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address; bits 1:0 are ignored |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for the word at `paddr` |

## Verification
The bound checker watches every cycle. It checks that a write with the enable bit set leaves lock set in that PLL word, and that DRAM and plain words hold exactly the written data, adjusted where required. It also checks that reset restores each default, that high addresses read zero and write nothing, and that no register moves outside a completed write. The bench's scenarios cover the rest. They show that holes below 0x308 read zero, that an aliasing high write leaves word 0x000 untouched, that a PLL write with enable clear keeps the written lock bit, and that these values come out on `prdata` in the cycle after the write. Only read-back through the bus port shows these.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 32;
    localparam int WORD_W      = ADDR_W - 2;
    localparam int NUM_REGS    = 27;
    localparam int WINDOW_END  = 'h308;
    localparam int PLL_EN_BIT  = 31;
    localparam int PLL_LK_BIT  = 28;
    localparam int DRAM_UP_BIT = 16;

    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_PLL   = 2'd1,
        KIND_DRAM  = 2'd2
    } reg_kind_e;

    typedef logic [DATA_W-1:0] word_t;

    // Byte offset of each storage slot.
    function automatic int unsigned slot_offset(int unsigned s);
        case (s)
            0:  return 'h000;  1:  return 'h008;  2:  return 'h010;
            3:  return 'h018;  4:  return 'h020;  5:  return 'h028;
            6:  return 'h038;  7:  return 'h044;  8:  return 'h048;
            9:  return 'h050;  10: return 'h054;  11: return 'h058;
            12: return 'h0F4;  13: return 'h0FC;  14: return 'h200;
            15: return 'h204;  16: return 'h220;  17: return 'h224;
            18: return 'h228;  19: return 'h22C;  20: return 'h230;
            21: return 'h234;  22: return 'h23C;  23: return 'h244;
            24: return 'h248;  25: return 'h250;  default: return 'h260;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] slot_word(int unsigned s);
        int unsigned wi;
        wi = slot_offset(s) >> 2;
        return wi[WORD_W-1:0];
    endfunction

    function automatic reg_kind_e slot_kind(int unsigned s);
        if (s <= 8)  return KIND_PLL;
        if (s == 12) return KIND_DRAM;
        return KIND_PLAIN;
    endfunction

    function automatic word_t slot_reset(int unsigned s);
        case (s)
            0, 4:               return 32'h0000_1000;
            1:                  return 32'h0003_5514;
            2, 3, 6, 8:         return 32'h0300_6207;
            5, 7:               return 32'h0004_1811;
            9:                  return 32'h0001_0000;
            10:                 return 32'h0000_1010;
            11:                 return 32'h0100_0000;
            12:                 return 32'h0000_0000;
            13:                 return 32'h8000_0000;
            14, 15:             return 32'h0000_00FF;
            16:                 return 32'h0810_0200;
            17, 18, 19, 22, 24: return 32'h1010_0000;
            20:                 return 32'h8110_4000;
            21, 23:             return 32'h1010_0010;
            25:                 return 32'h0A10_1000;
            default:            return 32'h1488_0000;
        endcase
    endfunction

    // Value actually stored for a write of d into a slot of kind k.
    function automatic word_t store_value(reg_kind_e k, word_t d);
        word_t r;
        r = d;
        if (k == KIND_PLL && d[PLL_EN_BIT]) r[PLL_LK_BIT] = 1'b1;
        if (k == KIND_DRAM)                 r[DRAM_UP_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
    import ccr_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] hit
);
    logic in_window;
    assign in_window = (int'(addr) < WINDOW_END);

    for (genvar s = 0; s < NUM_REGS; s++) begin : g_match
        localparam logic [WORD_W-1:0] MY_WORD = slot_word(s);
        assign hit[s] = in_window && (addr[ADDR_W-1:2] == MY_WORD);
    end
endmodule

// File: rtl/ccr_cell.sv
module ccr_cell
    import ccr_pkg::*;
#(
    parameter word_t     RESET_VAL = '0,
    parameter reg_kind_e KIND      = KIND_PLAIN
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  word_t wdata,
    output word_t q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= RESET_VAL;
        else if (we) q <= store_value(KIND, wdata);
    end
endmodule

// File: rtl/ccr_rdmux.sv
module ccr_rdmux
    import ccr_pkg::*;
(
    input  logic [NUM_REGS-1:0]             hit,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q,
    output word_t                           rdata
);
    always_comb begin
        rdata = '0;
        for (int s = 0; s < NUM_REGS; s++) begin
            if (hit[s]) rdata = rdata | regs_q[s];
        end
    end
endmodule

// File: rtl/ccr_bank.sv
module ccr_bank
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata
);
    logic                             wr_fire;
    logic [NUM_REGS-1:0]              hit;
    logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q;

    assign wr_fire = psel & penable & pwrite;

    ccr_decode u_decode (
        .addr (paddr),
        .hit  (hit)
    );

    for (genvar s = 0; s < NUM_REGS; s++) begin : g_slot
        ccr_cell #(
            .RESET_VAL (slot_reset(s)),
            .KIND      (slot_kind(s))
        ) u_cell (
            .clk   (clk),
            .rst   (rst),
            .we    (wr_fire & hit[s]),
            .wdata (pwdata),
            .q     (regs_q[s])
        );
    end

    ccr_rdmux u_rdmux (
        .hit    (hit),
        .regs_q (regs_q),
        .rdata  (prdata)
    );
endmodule

// File: rtl/ccr_bank_chk.sv
module ccr_bank_chk
    import ccr_pkg::*;
(
    input logic                             clk,
    input logic                             rst,
    input logic                             psel,
    input logic                             penable,
    input logic                             pwrite,
    input logic [ADDR_W-1:0]                paddr,
    input logic [DATA_W-1:0]                pwdata,
    input logic [DATA_W-1:0]                prdata,
    input logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
    logic fire, high;
    assign fire = psel && penable && pwrite;
    assign high = (int'(paddr) >= WINDOW_END);

    for (genvar s = 0; s < NUM_REGS; s++) begin : g_chk
        localparam logic [WORD_W-1:0] W  = slot_word(s);
        localparam word_t             RV = slot_reset(s);

        AST_RESET_DEFAULT: assert property (@(posedge clk)
            rst |=> regs_q[s] == RV); // R1

        if (slot_kind(s) == KIND_PLL) begin : g_pll
            AST_PLL_LOCK_ON_ENABLE: assert property (@(posedge clk) disable iff (rst)
                (fire && !high && paddr[ADDR_W-1:2] == W && pwdata[PLL_EN_BIT])
                |=> regs_q[s][PLL_LK_BIT]); // R2
            AST_PLL_DISABLED_VERBATIM: assert property (@(posedge clk) disable iff (rst)
                (fire && !high && paddr[ADDR_W-1:2] == W && !pwdata[PLL_EN_BIT])
                |=> regs_q[s] == $past(pwdata)); // R3
        end else if (slot_kind(s) == KIND_DRAM) begin : g_dram
            AST_DRAM_UPDATE_CLEARED: assert property (@(posedge clk) disable iff (rst)
                (fire && !high && paddr[ADDR_W-1:2] == W)
                |=> regs_q[s] == ($past(pwdata) & ~(32'h1 << DRAM_UP_BIT))); // R4
        end else begin : g_plain
            AST_PLAIN_VERBATIM: assert property (@(posedge clk) disable iff (rst)
                (fire && !high && paddr[ADDR_W-1:2] == W)
                |=> regs_q[s] == $past(pwdata)); // R5
        end
    end

    AST_HIGH_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        high |-> prdata == '0); // R6
    AST_HIGH_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (fire && high) |=> $stable(regs_q)); // R7
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(regs_q)); // R10
endmodule

bind ccr_bank ccr_bank_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .regs_q  (regs_q)
);

// File: tb/ccr_bank_bench.sv
`timescale 1ns/1ps
module ccr_bank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;  // 125 MHz

    ccr_bank u_ccr_bank (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata)
    );

    localparam int NV = 12;
    localparam logic [11:0] V_ADDR [NV] = '{
        12'h000, 12'h044, 12'h048, 12'h008, 12'h0F4, 12'h0F4,
        12'h050, 12'h220, 12'h250, 12'h260, 12'h038, 12'h200};
    localparam logic [31:0] V_DATA [NV] = '{
        32'h8000_0000, 32'h8000_1234, 32'h1000_0001, 32'h0000_0055,
        32'hFFFF_FFFF, 32'h0001_0003, 32'hDEAD_BEEF, 32'h1234_5678,
        32'hA5A5_A5A5, 32'h0F0F_0F0F, 32'h9FFF_FFFF, 32'h0000_0000};
    localparam logic [31:0] V_EXP [NV] = '{
        32'h9000_0000, 32'h9000_1234, 32'h1000_0001, 32'h0000_0055,
        32'hFFFE_FFFF, 32'h0000_0003, 32'hDEAD_BEEF, 32'h1234_5678,
        32'hA5A5_A5A5, 32'h0F0F_0F0F, 32'h9FFF_FFFF, 32'h0000_0000};

    function automatic string vec_tag(int i);
        case (i)
            0, 1, 10: return "R2";
            2, 3:     return "R3";
            4, 5:     return "R4";
            default:  return "R5";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d, bit with_enable = 1);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = with_enable;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        #1 d = prdata;
        psel = 1'b0;
    endtask

    task automatic expect_word(string tag, logic [11:0] a, logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(tag, d, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: defaults after reset
        expect_word("R1", 12'h000, 32'h0000_1000);
        expect_word("R1", 12'h0F4, 32'h0000_0000);
        expect_word("R1", 12'h0FC, 32'h8000_0000);
        expect_word("R1", 12'h200, 32'h0000_00FF);
        expect_word("R1", 12'h204, 32'h0000_00FF);
        expect_word("R1", 12'h230, 32'h8110_4000);
        expect_word("R1", 12'h260, 32'h1488_0000);

        // Vector table (R2..R5), read the cycle after each write (R9)
        for (int i = 0; i < NV; i++) begin
            bus_write(V_ADDR[i], V_DATA[i]);
            bus_read(V_ADDR[i], d);
            check(vec_tag(i), d, V_EXP[i]);
        end

        // R9: read immediately in the cycle after the completing edge
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = 12'h054; pwdata = 32'h0BAD_F00D;
        @(negedge clk) penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #1 check("R9", prdata, 32'h0BAD_F00D);

        // R6: reads at and above the window end are zero
        expect_word("R6", 12'h308, 32'h0);
        expect_word("R6", 12'hFFC, 32'h0);

        // R7: high write aliasing word 0x000 leaves it alone
        bus_write(12'h400, 32'h0000_0000);
        expect_word("R7", 12'h000, 32'h9000_0000);
        bus_write(12'h308, 32'hFFFF_FFFF);
        expect_word("R7", 12'h308, 32'h0);

        // R8: hole below the window end
        bus_write(12'h004, 32'hFFFF_FFFF);
        expect_word("R8", 12'h004, 32'h0);
        expect_word("R8", 12'h000, 32'h9000_0000);
        expect_word("R8", 12'h008, 32'h0000_0055);

        // R10: setup phase without penable writes nothing
        bus_write(12'h058, 32'h1111_1111, 0);
        expect_word("R10", 12'h058, 32'h0100_0000);

        // R1: reset again restores a written word
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        expect_word("R1", 12'h050, 32'h0001_0000);
        expect_word("R1", 12'h000, 32'h0000_1000);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule